// File: doc/BRIEF.md
# Banked Plug-and-Play Configuration Register Space

This block is the configuration register file of a peripheral controller that hosts several logical functions. Software reaches it through two byte-wide ports. A write to the index port selects a register. The data port then reads or writes that register. A device-select register picks which logical device's register bank answers the per-device indices. A small set of global registers holds the chip identification and two configuration bytes, and these answer no matter which bank is selected.

Each logical device has its own bank. A bank holds an activate register, one or two 16-bit I/O base addresses, interrupt number and type selects, two DMA channel selects and four vendor control bytes. From this state the block derives two things. The first is one activation line per device. The second is one address-match line per device and descriptor, against an incoming 16-bit I/O address. The function blocks use these lines to attach their resources and to claim I/O cycles.

Top module: `pnp_cfg_space`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata` as the current index on the next clock edge. A read with `bus_sel`=0 returns the stored index. The index resets to 00h.
- R2: Index 07h holds the device-select value as a full 8-bit register. The value selects the bank that answers per-device indices. Writes go only to the selected bank, and all other banks keep their contents.
- R3: Index 20h reads the constant CHIP_ID and index 27h reads the constant REV_ID. Both are read-only. Indices 21h and 22h are 8-bit read/write registers that do not depend on the device select.
- R4: A device that is not exempt is active exactly when bit 0 of its index 30h register and bit 0 of index 21h are both 1. The index 30h register reads back all 8 bits.
- R5: A device whose EXEMPT_MASK bit is set is active exactly when bit 0 of its own 30h register is 1. A device whose ALWAYS_ON_MASK bit is set is always active, including out of reset.
- R6: Index 60h holds bits 15:8 and index 61h holds bits 7:0 of base descriptor 0. Indices 62h and 63h do the same for descriptor 1, but only on devices whose BASE1_MASK bit is set. On other devices 62h and 63h are unimplemented.
- R7: Indices 70h, 71h, 74h, 75h and F0h through F3h are 8-bit read/write per-device registers.
- R8: A data write is ignored when its index is unimplemented or read-only (2Eh, 20h, 27h and every index not listed here), or when it is a per-device index and the device select is NUM_DEV or higher. A data read from such an index returns 00h.
- R9: `io_hit0[d]` is 1 exactly when device d is active and base0 <= `io_addr` < base0 + RANGE0. `io_hit1[d]` is 1 exactly when device d is active, its BASE1_MASK bit is set, and base1 <= `io_addr` < base1 + RANGE1. The comparison does not wrap past FFFFh.
- R10: After reset every register reads 00h, with two exceptions: the ID and revision constants, and base descriptor 0, which starts at its BASE0_RST slice (device d in bits 16d+15:16d).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe for a write |
| bus_write | input | 1 | 1 = write access |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port (combinational) |
| io_addr | input | 16 | I/O address to decode |
| dev_active | output | NUM_DEV | Per-device activation |
| io_hit0 | output | NUM_DEV | Per-device match on descriptor 0 |
| io_hit1 | output | NUM_DEV | Per-device match on descriptor 1 |

## Verification
Corrupt bank state cannot stay hidden. A register written in the wrong bank, or lost, reads back wrong on the data port as soon as that index is selected again. A full pass of reads over every bank exposes it within a few thousand cycles. A wrong activation term shows up on `dev_active` in the cycle after the write that changed it. A faulty base or range comparison shows up on the hit outputs at the first address at the edge of a window, which the full address sweep reaches in each activation mode.

// File: rtl/pnp_cfg_space.sv
`timescale 1ns/1ps
module pnp_cfg_space #(
  parameter int                     NUM_DEV        = 4,
  parameter logic [7:0]             CHIP_ID        = 8'hD3,
  parameter logic [7:0]             REV_ID         = 8'h02,
  parameter int                     RANGE0         = 8,
  parameter int                     RANGE1         = 4,
  parameter logic [NUM_DEV-1:0]     EXEMPT_MASK    = '0,
  parameter logic [NUM_DEV-1:0]     ALWAYS_ON_MASK = '0,
  parameter logic [NUM_DEV-1:0]     BASE1_MASK     = '1,
  parameter logic [16*NUM_DEV-1:0]  BASE0_RST      = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_sel,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [15:0]        io_addr,
  output logic [NUM_DEV-1:0] dev_active,
  output logic [NUM_DEV-1:0] io_hit0,
  output logic [NUM_DEV-1:0] io_hit1
);
  localparam int SW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [16:0] SPAN0 = 17'(RANGE0);
  localparam logic [16:0] SPAN1 = 17'(RANGE1);

  logic [7:0]  idx_q, ldn_q, cfg1_q, cfg2_q;
  logic [7:0]  act_q  [NUM_DEV];
  logic [15:0] b0_q   [NUM_DEV];
  logic [15:0] b1_q   [NUM_DEV];
  logic [7:0]  irqn_q [NUM_DEV];
  logic [7:0]  irqt_q [NUM_DEV];
  logic [7:0]  dma0_q [NUM_DEV];
  logic [7:0]  dma1_q [NUM_DEV];
  logic [7:0]  vnd_q  [NUM_DEV][4];
  logic [7:0]  reg_rd, dev_rd;

  wire          ldn_ok  = ldn_q < 8'(NUM_DEV);
  wire [SW-1:0] sel     = ldn_q[SW-1:0];
  wire          wr_idx  = bus_valid & bus_write & ~bus_sel;
  wire          wr_data = bus_valid & bus_write & bus_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      cfg1_q <= '0;
      cfg2_q <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        act_q[d]  <= '0;
        b0_q[d]   <= BASE0_RST[16*d +: 16];
        b1_q[d]   <= '0;
        irqn_q[d] <= '0;
        irqt_q[d] <= '0;
        dma0_q[d] <= '0;
        dma1_q[d] <= '0;
        for (int k = 0; k < 4; k++) vnd_q[d][k] <= '0;
      end
    end else begin
      if (wr_idx) idx_q <= bus_wdata;
      if (wr_data) begin
        case (idx_q)
          8'h07:   ldn_q  <= bus_wdata;
          8'h21:   cfg1_q <= bus_wdata;
          8'h22:   cfg2_q <= bus_wdata;
          default: ;
        endcase
      end
      for (int d = 0; d < NUM_DEV; d++) begin
        if (wr_data && ldn_ok && sel == SW'(d)) begin
          case (idx_q)
            8'h30: act_q[d]        <= bus_wdata;
            8'h60: b0_q[d][15:8]   <= bus_wdata;
            8'h61: b0_q[d][7:0]    <= bus_wdata;
            8'h62: if (BASE1_MASK[d]) b1_q[d][15:8] <= bus_wdata;
            8'h63: if (BASE1_MASK[d]) b1_q[d][7:0]  <= bus_wdata;
            8'h70: irqn_q[d]       <= bus_wdata;
            8'h71: irqt_q[d]       <= bus_wdata;
            8'h74: dma0_q[d]       <= bus_wdata;
            8'h75: dma1_q[d]       <= bus_wdata;
            8'hF0, 8'hF1, 8'hF2, 8'hF3: vnd_q[d][idx_q[1:0]] <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    dev_rd = '0;
    if (ldn_ok) begin
      case (idx_q)
        8'h30: dev_rd = act_q[sel];
        8'h60: dev_rd = b0_q[sel][15:8];
        8'h61: dev_rd = b0_q[sel][7:0];
        8'h62: dev_rd = BASE1_MASK[sel] ? b1_q[sel][15:8] : 8'h00;
        8'h63: dev_rd = BASE1_MASK[sel] ? b1_q[sel][7:0]  : 8'h00;
        8'h70: dev_rd = irqn_q[sel];
        8'h71: dev_rd = irqt_q[sel];
        8'h74: dev_rd = dma0_q[sel];
        8'h75: dev_rd = dma1_q[sel];
        8'hF0, 8'hF1, 8'hF2, 8'hF3: dev_rd = vnd_q[sel][idx_q[1:0]];
        default: dev_rd = '0;
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      8'h07:   reg_rd = ldn_q;
      8'h20:   reg_rd = CHIP_ID;
      8'h21:   reg_rd = cfg1_q;
      8'h22:   reg_rd = cfg2_q;
      8'h27:   reg_rd = REV_ID;
      default: reg_rd = dev_rd;
    endcase
  end

  assign bus_rdata = bus_sel ? reg_rd : idx_q;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    wire [16:0] a  = {1'b0, io_addr};
    wire [16:0] l0 = {1'b0, b0_q[d]};
    wire [16:0] l1 = {1'b0, b1_q[d]};

    assign dev_active[d] = ALWAYS_ON_MASK[d] |
                           (act_q[d][0] & (EXEMPT_MASK[d] | cfg1_q[0]));
    assign io_hit0[d] = dev_active[d] & (a >= l0) & (a < l0 + SPAN0);
    if (BASE1_MASK[d]) begin : g_b1
      assign io_hit1[d] = dev_active[d] & (a >= l1) & (a < l1 + SPAN1);
    end else begin : g_nob1
      assign io_hit1[d] = 1'b0;
    end

    p_bank_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && ldn_q != 8'(d)) |=> ($stable(b0_q[d]) && $stable(act_q[d])));
    p_hit_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_active[d] |-> (!io_hit0[d] && !io_hit1[d]));
  end

  p_index_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx_q == $past(bus_wdata));
  p_ldn_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && idx_q == 8'h07) |=> ldn_q == $past(bus_wdata));
  p_global_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg1_q[0] |-> (dev_active & ~(EXEMPT_MASK | ALWAYS_ON_MASK)) == '0);
  p_always_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_active & ALWAYS_ON_MASK) == ALWAYS_ON_MASK);
  p_reserved_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && idx_q == 8'h2E) |=> ($stable(cfg1_q) && $stable(cfg2_q) && $stable(ldn_q)));
endmodule

// File: tb/test_pnp_cfg_space.sv
`timescale 1ns/1ps
module test_pnp_cfg_space;
  localparam int ND = 4;
  localparam logic [7:0] ID = 8'hD3, REV = 8'h02;
  localparam int R0 = 8, R1 = 4;
  localparam logic [ND-1:0] EXM = 4'b0100, AON = 4'b1000, B1M = 4'b0011;
  localparam logic [16*ND-1:0] B0R = 64'h0070_0000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [15:0] io_addr = 0;
  logic [ND-1:0] dev_active, io_hit0, io_hit1;

  int vectors = 0, fails = 0;
  logic [7:0] mldn, m21, m22;
  logic [7:0] mdev [ND][256];

  always #2.5 clk = ~clk;

  pnp_cfg_space #(.NUM_DEV(ND), .CHIP_ID(ID), .REV_ID(REV), .RANGE0(R0), .RANGE1(R1),
    .EXEMPT_MASK(EXM), .ALWAYS_ON_MASK(AON), .BASE1_MASK(B1M), .BASE0_RST(B0R)) i_pnp_cfg_space (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_addr(io_addr),
    .dev_active(dev_active), .io_hit0(io_hit0), .io_hit1(io_hit1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit dev_impl(int d, logic [7:0] i);
    case (i)
      8'h30, 8'h60, 8'h61, 8'h70, 8'h71, 8'h74, 8'h75,
      8'hF0, 8'hF1, 8'hF2, 8'hF3: return 1'b1;
      8'h62, 8'h63: return B1M[d];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] i);
    case (i)
      8'h07: return "R2";
      8'h20, 8'h21, 8'h22, 8'h27: return "R3";
      8'h30: return "R4";
      8'h60, 8'h61, 8'h62, 8'h63: return "R6";
      8'h70, 8'h71, 8'h74, 8'h75, 8'hF0, 8'hF1, 8'hF2, 8'hF3: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] i);
    case (i)
      8'h07: return mldn;
      8'h20: return ID;
      8'h21: return m21;
      8'h22: return m22;
      8'h27: return REV;
      default: return (mldn < ND && dev_impl(int'(mldn), i)) ? mdev[mldn[1:0]][i] : 8'h00;
    endcase
  endfunction

  function automatic logic [ND-1:0] exp_act();
    logic [ND-1:0] r;
    for (int d = 0; d < ND; d++)
      r[d] = AON[d] | (mdev[d][8'h30][0] & (EXM[d] | m21[0]));
    return r;
  endfunction

  task automatic bus_wr(input logic s, input logic [7:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_sel = s; bus_wdata = v;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    bus_wr(0, i);
    bus_wr(1, v);
    case (i)
      8'h07: mldn = v;
      8'h21: m21 = v;
      8'h22: m22 = v;
      default: if (mldn < ND && dev_impl(int'(mldn), i)) mdev[mldn[1:0]][i] = v;
    endcase
  endtask

  task automatic reg_chk(input logic [7:0] i);
    bus_wr(0, i);
    bus_sel = 0; #1;
    chk("R1 index readback", {24'h0, bus_rdata}, {24'h0, i});
    bus_sel = 1; #1;
    chk(req_of(i), {24'h0, bus_rdata}, {24'h0, exp_rd(i)});
  endtask

  task automatic hit_sweep(input string tag);
    for (int a = 0; a < 65536; a++) begin
      logic [ND-1:0] e0, e1;
      logic [ND-1:0] ea;
      io_addr = 16'(a);
      ea = exp_act();
      for (int d = 0; d < ND; d++) begin
        int b0, b1;
        b0 = {mdev[d][8'h60], mdev[d][8'h61]};
        b1 = {mdev[d][8'h62], mdev[d][8'h63]};
        e0[d] = ea[d] && a >= b0 && a < b0 + R0;
        e1[d] = ea[d] && B1M[d] && a >= b1 && a < b1 + R1;
      end
      #1;
      chk({"R9 hit0 ", tag}, {28'h0, io_hit0}, {28'h0, e0});
      chk({"R9 hit1 ", tag}, {28'h0, io_hit1}, {28'h0, e1});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    mldn = 0; m21 = 0; m22 = 0;
    for (int d = 0; d < ND; d++)
      for (int i = 0; i < 256; i++) mdev[d][i] = 8'h00;
    mdev[3][8'h60] = 8'h00; mdev[3][8'h61] = 8'h70;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 reset index", {24'h0, bus_rdata}, 32'h0);
    chk("R10 R5 reset activation", {28'h0, dev_active}, {28'h0, AON});
    for (int i = 0; i < 256; i++) reg_chk(8'(i));

    for (int pass = 0; pass < 2; pass++) begin
      for (int ld = 0; ld <= ND; ld++) begin
        reg_wr(8'h07, 8'(ld));
        for (int i = 0; i < 256; i++) begin
          logic [7:0] v;
          if (i == 7) continue;
          v = 8'(i * 7 + ld * 29 + 5);
          if (pass == 1) v = ~v;
          reg_wr(8'(i), v);
          bus_sel = 1; #1;
          chk(req_of(8'(i)), {24'h0, bus_rdata}, {24'h0, exp_rd(8'(i))});
          chk("R4 R5 activation", {28'h0, dev_active}, {28'h0, exp_act()});
        end
      end
      for (int ld = 0; ld <= ND; ld++) begin
        reg_wr(8'h07, 8'(ld));
        for (int i = 0; i < 256; i++) reg_chk(8'(i));
      end
    end
    reg_wr(8'h07, 8'hC5);
    reg_chk(8'h07);

    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 16; p++) begin
        reg_wr(8'h21, 8'(g) | 8'hA4);
        for (int d = 0; d < ND; d++) begin
          reg_wr(8'h07, 8'(d));
          reg_wr(8'h30, {7'h55, p[d]});
        end
        #1;
        chk(g ? "R4 R5 activation enabled" : "R4 R5 activation disabled",
            {28'h0, dev_active}, {28'h0, exp_act()});
      end

    reg_wr(8'h07, 0); reg_wr(8'h60, 8'h01); reg_wr(8'h61, 8'h00);
    reg_wr(8'h62, 8'h02); reg_wr(8'h63, 8'h00);
    reg_wr(8'h07, 1); reg_wr(8'h60, 8'h01); reg_wr(8'h61, 8'h04);
    reg_wr(8'h62, 8'hFF); reg_wr(8'h63, 8'hFE);
    reg_wr(8'h07, 2); reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'h00);
    reg_wr(8'h62, 8'h04); reg_wr(8'h63, 8'h00);
    reg_wr(8'h07, 3); reg_wr(8'h60, 8'hFF); reg_wr(8'h61, 8'hFC);
    for (int d = 0; d < ND; d++) begin
      reg_wr(8'h07, 8'(d)); reg_wr(8'h30, 8'h01);
    end
    reg_wr(8'h21, 8'h01);
    hit_sweep("global on");
    reg_wr(8'h21, 8'h00);
    hit_sweep("global off");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule